// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block chooses which of four DMA channels is served next. Each channel can raise a request in two ways. The first is a hardware request pin, whose active level is programmable and which can be masked. The second is a software request bit that a single register write sets or clears. Eligible requests feed one priority picker. That picker runs either in a fixed order or in a rotating order, where the channel just granted becomes the lowest.

A grant is held until the transfer engine signals that the service is over. The block then looks at the requests again. The grant leaves the block in two forms: a one-hot acknowledge vector with programmable polarity, and an encoded channel number with an active flag. A terminal count or an external end-of-process during a service clears the software request of the serviced channel. A configuration bit can stop the whole arbiter. A master clear returns the configuration, the masks, the software requests and the rotation to their reset values.

Top module: `dma_req_arb`

## Requirements
- R1: After reset there is no grant: `active_o`=0, `act_ch_o`=0, `dack_o`=4'b1111 (acknowledge active low). The software requests, the configuration and the rotation pointer are cleared, and all four masks are set.
- R2: A pulse on `req_wr_i` writes one software request bit. `req_data_i[1:0]` selects the channel, and `req_data_i[2]` sets the bit (1) or clears it (0). Bits 7:3 have no effect.
- R3: A software request bit is eligible only while that channel's `blk_mode_i` bit is 1. The mask never gates it.
- R4: A hardware request on `dreq_i` is eligible only while that channel's mask bit is 0. `mask_wr_i` loads all four masks from `mask_i`.
- R5: Configuration bit 2 (`cmd_i[2]`, loaded by `cmd_wr_i`) selects the request sense: 0 means active high, 1 means active low.
- R6: With configuration bit 1 at 0 (fixed order), the lowest-numbered eligible channel wins.
- R7: With configuration bit 1 at 1 (rotating order), the search starts at the channel after the one granted last. A new grant to channel k moves the start to k+1 modulo 4.
- R8: While idle, an eligible request in one cycle makes the grant visible after the next clock edge. A grant holds its channel until `done_i`. The edge that sees `done_i` returns the block to idle, and a new grant can start at the following edge.
- R9: While a grant is active, `tc_i` or `eop_i` clears the software request bit of the granted channel. When a write to the same bit falls in the same cycle, the clear wins.
- R10: `dack_o` carries the granted channel as a one-hot vector. It is active high when configuration bit 3 is 1 and active low when it is 0. `act_ch_o` gives the granted channel and reads 0 while idle.
- R11: While configuration bit 0 is 1, the controller is disabled: no grant starts, and an active grant ends at the next edge.
- R12: `mclr_i` restores the reset values of the configuration, the masks, the software requests, the rotation pointer and the grant at the next edge. It takes priority over writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclr_i | input | 1 | Synchronous master clear |
| cmd_wr_i | input | 1 | Configuration write strobe |
| cmd_i | input | 4 | Configuration: bit0 disable, bit1 rotate, bit2 request active low, bit3 acknowledge active high |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_i | input | 4 | New mask bits, 1 blocks the hardware request |
| req_wr_i | input | 1 | Software request write strobe |
| req_data_i | input | 8 | Software request write data |
| blk_mode_i | input | 4 | Per-channel block-mode flag from the mode logic |
| dreq_i | input | 4 | Hardware request pins |
| done_i | input | 1 | Current service finished |
| tc_i | input | 1 | Terminal count of the granted channel |
| eop_i | input | 1 | External end of process |
| dack_o | output | 4 | Acknowledge lines, programmable polarity |
| active_o | output | 1 | A grant is active |
| act_ch_o | output | 2 | Granted channel number |

## Verification
The assertions do not restrict the inputs, so any sequence of strobes, pins and service signals is legal. They do rely on one design choice: the configuration, the masks and the software requests used in a cycle are the registered values from before that cycle's writes. The random stimulus drives every strobe freely, including `tc_i` and `eop_i` outside a grant. It sets the disable bit and `mclr_i` only rarely, so that grants, holds and rotations happen often. Directed sequences cover the priority orders, the ignored data bits, a clear colliding with a write, and both polarity settings.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // layout matches cmd_i[3:0]
  typedef struct packed {
    logic dack_high;
    logic dreq_low;
    logic rotate;
    logic off;
  } dma_cfg_t;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  input  logic [CW-1:0]  base_i,
  output logic           valid_o,
  output logic [CW-1:0]  ch_o
);
  logic [NCH-1:0] rot;
  logic [CW-1:0]  ofs;

  // rotate so that base_i sits at position 0 (NCH is a power of two)
  for (genvar g = 0; g < NCH; g++) begin : g_rot
    logic [CW-1:0] idx;
    assign idx    = base_i + CW'(g);
    assign rot[g] = req_i[idx];
  end

  always_comb begin
    ofs = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rot[i]) ofs = CW'(i);
    end
    valid_o = |rot;
    ch_o    = base_i + ofs;
  end

  always_comb begin
    if (valid_o) a_r6_pick_legal: assert (req_i[ch_o]);
  end
endmodule

// File: rtl/dma_req_reg.sv
module dma_req_reg #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mclr_i,
  input  logic           wr_i,
  input  logic [CW-1:0]  wr_ch_i,
  input  logic           wr_set_i,
  input  logic           clr_i,
  input  logic [CW-1:0]  clr_ch_i,
  output logic [NCH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (mclr_i) begin
      q_o <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (clr_i && clr_ch_i == CW'(c))     q_o[c] <= 1'b0;  // clear wins
        else if (wr_i && wr_ch_i == CW'(c))  q_o[c] <= wr_set_i;
      end
    end
  end

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o[$past(clr_ch_i)]);

  a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_set_i && !mclr_i && !(clr_i && clr_ch_i == wr_ch_i))
    |=> q_o[$past(wr_ch_i)]);

  a_r12_mclr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (q_o == '0));
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb import dma_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mclr_i,
  input  logic           cmd_wr_i,
  input  logic [3:0]     cmd_i,
  input  logic           mask_wr_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           req_wr_i,
  input  logic [DW-1:0]  req_data_i,
  input  logic [NCH-1:0] blk_mode_i,
  input  logic [NCH-1:0] dreq_i,
  input  logic           done_i,
  input  logic           tc_i,
  input  logic           eop_i,
  output logic [NCH-1:0] dack_o,
  output logic           active_o,
  output logic [CW-1:0]  act_ch_o
);
  dma_cfg_t       cfg_q;
  logic [NCH-1:0] mask_q, sw_q, hw_req, elig, gvec;
  logic           busy_q, pick_v, clr;
  logic [CW-1:0]  cur_q, top_q, base, pick_ch;
  logic           unused_req_bits;

  assign unused_req_bits = ^req_data_i[DW-1:CW+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '1;
    end else if (mclr_i) begin
      cfg_q  <= '0;
      mask_q <= '1;
    end else begin
      if (cmd_wr_i)  cfg_q  <= dma_cfg_t'(cmd_i);
      if (mask_wr_i) mask_q <= mask_i;
    end
  end

  assign clr = busy_q & (tc_i | eop_i);

  dma_req_reg #(.NCH(NCH)) i_req_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mclr_i   (mclr_i),
    .wr_i     (req_wr_i),
    .wr_ch_i  (req_data_i[CW-1:0]),
    .wr_set_i (req_data_i[CW]),
    .clr_i    (clr),
    .clr_ch_i (cur_q),
    .q_o      (sw_q)
  );

  assign hw_req = (cfg_q.dreq_low ? ~dreq_i : dreq_i) & ~mask_q;
  assign elig   = hw_req | (sw_q & blk_mode_i);
  assign base   = cfg_q.rotate ? top_q : '0;

  dma_prio_pick #(.NCH(NCH)) i_pick (
    .req_i   (elig),
    .base_i  (base),
    .valid_o (pick_v),
    .ch_o    (pick_ch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      top_q  <= '0;
    end else if (mclr_i) begin
      busy_q <= 1'b0;
      top_q  <= '0;
    end else if (cfg_q.off) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (pick_v) begin
      busy_q <= 1'b1;
      cur_q  <= pick_ch;
      if (cfg_q.rotate) top_q <= pick_ch + CW'(1);
    end
  end

  assign gvec     = busy_q ? (NCH'(1) << cur_q) : '0;
  assign dack_o   = cfg_q.dack_high ? gvec : ~gvec;
  assign active_o = busy_q;
  assign act_ch_o = busy_q ? cur_q : '0;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i && !mclr_i && !cfg_q.off) |=> (busy_q && $stable(cur_q)));

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && pick_v && !mclr_i && !cfg_q.off) |=> busy_q);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q);

  a_r11_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.off |=> !active_o);

  a_r7_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && pick_v && cfg_q.rotate && !mclr_i && !cfg_q.off)
    |=> (top_q == cur_q + CW'(1)));

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_q.dack_high ? dack_o : ~dack_o));
endmodule

// File: tb/test_dma_req_arb.sv
module test_dma_req_arb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       mclr_i = 0, cmd_wr_i = 0, mask_wr_i = 0, req_wr_i = 0;
  logic [3:0] cmd_i = 0, mask_i = 0, blk_mode_i = 0, dreq_i = 0;
  logic [7:0] req_data_i = 0;
  logic       done_i = 0, tc_i = 0, eop_i = 0;
  logic [3:0] dack_o;
  logic       active_o;
  logic [1:0] act_ch_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  logic [3:0] m_sw, m_mask, m_cfg;
  logic       m_busy;
  logic [1:0] m_cur, m_top;

  always #10 clk_i = ~clk_i;

  dma_req_arb i_dma_req_arb (
    .clk_i, .rst_ni, .mclr_i, .cmd_wr_i, .cmd_i, .mask_wr_i, .mask_i,
    .req_wr_i, .req_data_i, .blk_mode_i, .dreq_i, .done_i, .tc_i, .eop_i,
    .dack_o, .active_o, .act_ch_o
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_model(string req);
    logic [3:0] g;
    g = m_busy ? (4'b1 << m_cur) : 4'b0;
    chk({req, " dack"}, {4'b0, dack_o}, {4'b0, m_cfg[3] ? g : ~g});
    chk({req, " active"}, {7'b0, active_o}, {7'b0, m_busy});
    chk({req, " ch"}, {6'b0, act_ch_o}, {6'b0, m_busy ? m_cur : 2'd0});
  endtask

  // one clock: advance reference from current stimulus, then compare
  task automatic tick(string req);
    logic [3:0] hw, el, n_sw;
    logic [1:0] base, p;
    logic pv;
    hw = (m_cfg[2] ? ~dreq_i : dreq_i) & ~m_mask;
    el = hw | (m_sw & blk_mode_i);
    base = m_cfg[1] ? m_top : 2'd0;
    pv = 0; p = 0;
    for (int i = 3; i >= 0; i--) if (el[base + 2'(i)]) begin pv = 1; p = base + 2'(i); end
    n_sw = m_sw;
    if (req_wr_i) n_sw[req_data_i[1:0]] = req_data_i[2];
    if (m_busy && (tc_i || eop_i)) n_sw[m_cur] = 1'b0;
    @(posedge clk_i);
    #2;
    if (mclr_i) begin
      m_sw = 0; m_mask = 4'hF; m_cfg = 0; m_busy = 0; m_top = 0;
    end else begin
      m_sw = n_sw;
      if (m_cfg[0]) m_busy = 0;
      else if (m_busy) begin if (done_i) m_busy = 0; end
      else if (pv) begin m_busy = 1; m_cur = p; if (m_cfg[1]) m_top = p + 2'd1; end
      if (mask_wr_i) m_mask = mask_i;
      if (cmd_wr_i) m_cfg = cmd_i;
    end
    chk_model(req);
  endtask

  task automatic quiet();
    mclr_i = 0; cmd_wr_i = 0; mask_wr_i = 0; req_wr_i = 0;
    done_i = 0; tc_i = 0; eop_i = 0;
  endtask

  task automatic idle_out();
    dreq_i = 0; quiet(); done_i = 1; tick("R8 release"); quiet();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_sw = 0; m_mask = 4'hF; m_cfg = 0; m_busy = 0; m_cur = 0; m_top = 0;
    #5;
    chk("R1 reset dack", {4'b0, dack_o}, 8'h0F);
    chk("R1 reset active", {7'b0, active_o}, 8'h00);
    chk("R1 reset ch", {6'b0, act_ch_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1;
    // masks set at reset: hardware requests blocked
    dreq_i = 4'hF; tick("R1 masked"); tick("R1 masked");
    chk("R1 R4 no grant while masked", {7'b0, active_o}, 8'h00);

    // R4 mask write opens channel 2
    mask_wr_i = 1; mask_i = 4'h0; dreq_i = 4'b0100; tick("R4"); quiet();
    tick("R8 latency");
    chk("R4 grant ch2", {6'b0, act_ch_o}, 8'h02);
    chk("R10 dack low ch2", {4'b0, dack_o}, 8'h0B);
    dreq_i = 4'b0001; tick("R8 hold"); tick("R8 hold");
    chk("R8 hold ch2", {6'b0, act_ch_o}, 8'h02);
    idle_out();

    // R6 fixed order
    dreq_i = 4'b1010; tick("R6"); chk("R6 fixed picks ch1", {6'b0, act_ch_o}, 8'h01);
    done_i = 1; tick("R8"); quiet(); tick("R6 again");
    chk("R6 fixed repeats ch1", {6'b0, act_ch_o}, 8'h01);
    idle_out();

    // R7 rotating order
    cmd_wr_i = 1; cmd_i = 4'b0010; tick("R7 cfg"); quiet();
    dreq_i = 4'hF;
    for (int k = 0; k < 5; k++) begin
      tick("R7 grant");
      chk("R7 rotation", {6'b0, act_ch_o}, 8'(k % 4));
      done_i = 1; tick("R7 done"); quiet();
    end
    idle_out();
    cmd_wr_i = 1; cmd_i = 4'b0000; tick("R7 back"); quiet();

    // R3 software request needs block mode, not masked
    mask_wr_i = 1; mask_i = 4'hF; tick("R3"); quiet();
    blk_mode_i = 4'b0000;
    req_wr_i = 1; req_data_i = 8'b0000_0111; tick("R2 set ch3"); quiet();
    tick("R3 no blk"); chk("R3 not in block mode", {7'b0, active_o}, 8'h00);
    blk_mode_i = 4'b1000; tick("R3 blk");
    chk("R3 block mode grant ch3", {6'b0, act_ch_o}, 8'h03);
    // R9 terminal count clears the bit
    tc_i = 1; done_i = 1; tick("R9 tc"); quiet(); tick("R9");
    chk("R9 tc cleared sw ch3", {7'b0, active_o}, 8'h00);

    // R2 upper data bits ignored: 0xFD sets ch1 only
    blk_mode_i = 4'hF;
    req_wr_i = 1; req_data_i = 8'hFD; tick("R2"); quiet();
    tick("R2 grant"); chk("R2 ignored bits ch1", {6'b0, act_ch_o}, 8'h01);
    // R9 clear wins over same-cycle set, via eop
    eop_i = 1; req_wr_i = 1; req_data_i = 8'h05; tick("R9 eop"); quiet();
    done_i = 1; tick("R9"); quiet(); tick("R9 after");
    chk("R9 clear wins", {7'b0, active_o}, 8'h00);

    // R5 request active low, R10 acknowledge active high
    cmd_wr_i = 1; cmd_i = 4'b1100; mask_wr_i = 1; mask_i = 4'h0; dreq_i = 4'hF;
    tick("R5 cfg"); quiet();
    dreq_i = 4'b1011; tick("R5");
    chk("R5 low sense ch2", {6'b0, act_ch_o}, 8'h02);
    chk("R10 dack high ch2", {4'b0, dack_o}, 8'h04);
    // R11 disable drops the grant
    cmd_wr_i = 1; cmd_i = 4'b1101; tick("R11 cfg"); quiet();
    tick("R11"); chk("R11 disabled", {7'b0, active_o}, 8'h00);
    tick("R11"); chk("R11 stays idle", {4'b0, dack_o}, 8'h00);
    // R12 master clear
    mclr_i = 1; cmd_wr_i = 1; cmd_i = 4'b0010; tick("R12"); quiet();
    dreq_i = 4'h0; tick("R12 after");
    chk("R12 dack default", {4'b0, dack_o}, 8'h0F);
    chk("R12 idle", {7'b0, active_o}, 8'h00);

    // constrained random mix, all requirements checked via the model
    for (int n = 0; n < 4000; n++) begin
      dreq_i     = 4'($urandom);
      blk_mode_i = 4'($urandom);
      done_i     = ($urandom % 4) == 0;
      tc_i       = ($urandom % 8) == 0;
      eop_i      = ($urandom % 16) == 0;
      req_wr_i   = ($urandom % 4) == 0;
      req_data_i = 8'($urandom);
      mask_wr_i  = ($urandom % 8) == 0;
      mask_i     = 4'($urandom);
      cmd_wr_i   = ($urandom % 16) == 0;
      cmd_i      = 4'($urandom) & (($urandom % 4) == 0 ? 4'hF : 4'hE);
      mclr_i     = ($urandom % 300) == 0;
      tick("R1-R12 random");
    end
    quiet();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule